// File: doc/BRIEF.md
# Double-Scan Parity Error Corrector

This block sits on the controller side of a serial link that reads an 8-input status word from a remote input terminator. Each 16-bit word carries eight data bits, a full-byte parity bit, three overlapping nibble parity bits, two alarm bits and a pair of stop bits. The block checks every word as it arrives. A word with good stop bits and a matching full parity is delivered at once as the data byte.

When the full parity of a first word fails, the block keeps that word and pulses a rescan request. The surrounding transport then fetches a second word. The three nibble parities of each scan point to a quarter of the byte that may hold the flipped bit. Each scan is assumed to carry at most one error, and the two errors are assumed to fall on different bits. The corrector takes the suspect quarter of the first scan from the second scan and keeps every other bit from the first scan. If the suspect regions of the two scans overlap, the block reports the byte as uncorrectable. A word with wrong stop bits is reported as a link or power fault and is never used.

Top module: `dscan_fixer`

## Requirements
- R1: Word layout: data input k (k = 1..8) is at word bit 7+k, so word[15:8] is the data byte with input 8 as the MSB. The parity bits are word[5] = full (XNOR of all eight data bits), word[4] = upper (XNOR of inputs 5..8), word[3] = lower (XNOR of inputs 1..4) and word[2] = middle (XNOR of inputs 3..6). The alarm bits word[7:6] are not checked. A byte is delivered without correction only if word[5] equals the XNOR of word[15:8].
- R2: In idle, a valid word with good stop bits and a matching full parity makes byte_vld high for exactly one cycle. The pulse comes in the cycle after the word. byte_out then equals word[15:8], byte_fixed is 0 and rescan_req stays low.
- R3: A word whose stop bits are not word[1] = 0 and word[0] = 1 makes link_fault pulse for one cycle in the cycle after the word. No byte is delivered and no rescan is requested. A fault on the second scan also ends the pending correction and returns the block to idle.
- R4: In idle, a valid word with good stop bits and a failing full parity makes rescan_req pulse for one cycle in the cycle after the word. The word is stored and byte_vld stays low.
- R5: Each scan gets a suspect mask. The mask is empty when the scan's full parity matches. Otherwise it is set from the failing nibble checks: lower only gives inputs 1..2, lower and middle give inputs 3..4, middle and upper give inputs 5..6, upper only gives inputs 7..8. The second scan then yields byte_vld and byte_fixed for one cycle. byte_out takes the bits under the first scan's mask from the second scan and all other bits from the first scan.
- R6: If the first scan fails full parity while all three nibble checks pass, its mask is empty and the corrected byte equals the first scan's data byte.
- R7: If the two masks share any bit, uncorrectable pulses for one cycle after the second scan and byte_vld stays low.
- R8: After reset every output is 0 and the block is idle.
- R9: A failing full parity with any nibble pattern not listed in R5 marks the whole byte as suspect.
- R10: A second scan whose full parity matches has an empty mask, even if one of its nibble parity bits disagrees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | word_in holds a received scan this cycle |
| word_in | input | 16 | Received status word |
| rescan_req | output | 1 | One-cycle request for a second scan |
| byte_out | output | 8 | Delivered data byte |
| byte_vld | output | 1 | One-cycle strobe: byte_out is new |
| byte_fixed | output | 1 | The delivered byte came from two-scan correction |
| link_fault | output | 1 | One-cycle pulse: stop bits wrong |
| uncorrectable | output | 1 | One-cycle pulse: suspect regions of the two scans overlap |

## Verification
The hardest case to reach is the inconsistent nibble pattern of R9. A single flipped bit can never produce it, so the bench builds a first scan with two data flips plus a flipped full parity bit. That scan fails full parity while the lower and upper checks fail together. The bench then expects the whole byte to come from the second scan. The overlap and second-scan fault paths are reached the same way: the bench builds pairs of scans with chosen bit flips from a parity generator written from the word layout. After a fault, the bench sends a clean word to show that the block has returned to idle.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int DATA_W  = 8;
  localparam int WORD_W  = 2 * DATA_W;
  localparam int NIB_W   = DATA_W / 2;
  localparam int QTR_W   = DATA_W / 4;
  localparam int NUM_NIB = 3;
  localparam int FULL_POS   = 5;
  localparam int STOPLO_POS = 1;
  localparam int STOPHI_POS = 0;

  typedef enum logic { ST_IDLE, ST_WAIT } fix_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
    logic              full_bad;
    logic              stop_ok;
  } scan_info_t;

  // region 0 = lower, 1 = middle, 2 = upper
  function automatic int nib_start(int i);
    return i * (NIB_W / 2);
  endfunction

  function automatic int nib_par_pos(int i);
    case (i)
      0:       return 3;
      1:       return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] quarter_mask(int k);
    logic [DATA_W-1:0] m;
    m = '0;
    m[k*QTR_W +: QTR_W] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] region_mask(logic [NUM_NIB-1:0] nb);
    case (nb)
      3'b000:  return '0;
      3'b001:  return quarter_mask(0);
      3'b011:  return quarter_mask(1);
      3'b110:  return quarter_mask(2);
      3'b100:  return quarter_mask(3);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/dscan_rst_sync.sv
module dscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/dscan_decode.sv
module dscan_decode
  import dscan_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output scan_info_t        info_o
);
  logic [DATA_W-1:0]  data;
  logic [NUM_NIB-1:0] nib_bad;
  logic               full_bad;
  logic               unused_alarm;

  assign data         = word_i[WORD_W-1:DATA_W];
  assign full_bad     = (~^data) != word_i[FULL_POS];
  assign unused_alarm = ^word_i[7:6];

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    assign nib_bad[i] = (~^data[nib_start(i) +: NIB_W]) != word_i[nib_par_pos(i)];
  end

  always_comb begin
    info_o.data     = data;
    info_o.full_bad = full_bad;
    info_o.mask     = full_bad ? region_mask(nib_bad) : '0;
    info_o.stop_ok  = !word_i[STOPLO_POS] && word_i[STOPHI_POS];
  end
endmodule

// File: rtl/dscan_merge.sv
module dscan_merge
  import dscan_pkg::*;
(
  input  logic [DATA_W-1:0] d1_i,
  input  logic [DATA_W-1:0] m1_i,
  input  logic [DATA_W-1:0] d2_i,
  input  logic [DATA_W-1:0] m2_i,
  output logic [DATA_W-1:0] merged_o,
  output logic              overlap_o
);
  assign merged_o  = (d1_i & ~m1_i) | (d2_i & m1_i);
  assign overlap_o = |(m1_i & m2_i);
endmodule

// File: rtl/dscan_ctrl.sv
module dscan_ctrl
  import dscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  scan_info_t        info_i,
  input  logic [DATA_W-1:0] merged_i,
  input  logic              overlap_i,
  output logic [DATA_W-1:0] d1_o,
  output logic [DATA_W-1:0] m1_o,
  output logic              rescan_req,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              byte_fixed,
  output logic              link_fault,
  output logic              uncorrectable
);
  fix_state_t        st_q, st_d;
  logic [DATA_W-1:0] d1_q, m1_q, byte_q, byte_d;
  logic              d1_en, byte_en;
  logic              vld_q, vld_d, fix_q, fix_d;
  logic              resc_q, resc_d, flt_q, flt_d, unc_q, unc_d;

  always_comb begin
    st_d    = st_q;
    d1_en   = 1'b0;
    byte_en = 1'b0;
    byte_d  = info_i.data;
    vld_d   = 1'b0;
    fix_d   = 1'b0;
    resc_d  = 1'b0;
    flt_d   = 1'b0;
    unc_d   = 1'b0;
    if (word_vld) begin
      if (!info_i.stop_ok) begin
        flt_d = 1'b1;
        st_d  = ST_IDLE;
      end else if (st_q == ST_IDLE) begin
        if (!info_i.full_bad) begin
          byte_en = 1'b1;
          vld_d   = 1'b1;
        end else begin
          d1_en  = 1'b1;
          resc_d = 1'b1;
          st_d   = ST_WAIT;
        end
      end else begin
        st_d = ST_IDLE;
        if (overlap_i) begin
          unc_d = 1'b1;
        end else begin
          byte_en = 1'b1;
          byte_d  = merged_i;
          vld_d   = 1'b1;
          fix_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vld_q  <= 1'b0;
      fix_q  <= 1'b0;
      resc_q <= 1'b0;
      flt_q  <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      vld_q  <= vld_d;
      fix_q  <= fix_d;
      resc_q <= resc_d;
      flt_q  <= flt_d;
      unc_q  <= unc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= '0;
      m1_q <= '0;
    end else if (d1_en) begin
      d1_q <= info_i.data;
      m1_q <= info_i.mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= byte_d;
  end

  assign d1_o          = d1_q;
  assign m1_o          = m1_q;
  assign rescan_req    = resc_q;
  assign byte_out      = byte_q;
  assign byte_vld      = vld_q;
  assign byte_fixed    = fix_q;
  assign link_fault    = flt_q;
  assign uncorrectable = unc_q;
endmodule

// File: rtl/dscan_fixer.sv
module dscan_fixer
  import dscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              rescan_req,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              byte_fixed,
  output logic              link_fault,
  output logic              uncorrectable
);
  logic              rst_q_n;
  scan_info_t        info;
  logic [DATA_W-1:0] d1, m1, merged;
  logic              overlap;

  dscan_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dscan_decode u_dec (
    .word_i (word_in),
    .info_o (info)
  );

  dscan_merge u_mrg (
    .d1_i      (d1),
    .m1_i      (m1),
    .d2_i      (info.data),
    .m2_i      (info.mask),
    .merged_o  (merged),
    .overlap_o (overlap)
  );

  dscan_ctrl u_ctl (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .word_vld      (word_vld),
    .info_i        (info),
    .merged_i      (merged),
    .overlap_i     (overlap),
    .d1_o          (d1),
    .m1_o          (m1),
    .rescan_req    (rescan_req),
    .byte_out      (byte_out),
    .byte_vld      (byte_vld),
    .byte_fixed    (byte_fixed),
    .link_fault    (link_fault),
    .uncorrectable (uncorrectable)
  );
endmodule

// File: rtl/dscan_fixer_chk.sv
module dscan_fixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_vld,
  input logic [15:0] word_in,
  input logic        rescan_req,
  input logic [7:0]  byte_out,
  input logic        byte_vld,
  input logic        byte_fixed,
  input logic        link_fault,
  input logic        uncorrectable
);
  // R2
  plain_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_fixed) |-> ($past(word_vld) && byte_out == $past(word_in[15:8])));

  // R1
  plain_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_fixed) |-> ((~^$past(word_in[15:8])) == $past(word_in[5])));

  // R3
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fault |-> ($past(word_vld) && !($past(word_in[0]) && !$past(word_in[1]))));

  // R4
  rescan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_req |=> !rescan_req);

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, rescan_req, link_fault, uncorrectable}));

  // R5
  fixed_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fixed |-> byte_vld);

  // R7
  unc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> $past(word_vld));
endmodule

bind dscan_fixer dscan_fixer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .word_vld      (word_vld),
  .word_in       (word_in),
  .rescan_req    (rescan_req),
  .byte_out      (byte_out),
  .byte_vld      (byte_vld),
  .byte_fixed    (byte_fixed),
  .link_fault    (link_fault),
  .uncorrectable (uncorrectable)
);

// File: tb/sim_dscan_fixer.sv
`timescale 1ns/1ps
module sim_dscan_fixer;
  logic        clk;
  logic        rst_n;
  logic        word_vld;
  logic [15:0] word_in;
  logic        rescan_req;
  logic [7:0]  byte_out;
  logic        byte_vld;
  logic        byte_fixed;
  logic        link_fault;
  logic        uncorrectable;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dscan_fixer u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_vld      (word_vld),
    .word_in       (word_in),
    .rescan_req    (rescan_req),
    .byte_out      (byte_out),
    .byte_vld      (byte_vld),
    .byte_fixed    (byte_fixed),
    .link_fault    (link_fault),
    .uncorrectable (uncorrectable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // word per R1: data, alarms high, full, upper, lower, middle, stop 0, stop 1
  function automatic logic [15:0] mk(input logic [7:0] d);
    return {d, 1'b1, 1'b1, ~^d, ~^d[7:4], ~^d[3:0], ~^d[5:2], 1'b0, 1'b1};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    word_vld = 1'b1;
    word_in  = w;
    @(negedge clk);
    word_vld = 1'b0;
    word_in  = 16'h0;
  endtask

  task automatic expect_out(input string req, input logic vld, input logic [7:0] b,
                            input logic fix, input logic resc, input logic flt,
                            input logic unc);
    check(req, "byte_vld", byte_vld, vld);
    if (vld) check(req, "byte_out", byte_out, b);
    check(req, "byte_fixed", byte_fixed, fix);
    check(req, "rescan_req", rescan_req, resc);
    check(req, "link_fault", link_fault, flt);
    check(req, "uncorrectable", uncorrectable, unc);
  endtask

  task automatic t_reset();
    expect_out("R8", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", "byte_out", byte_out, 8'h00);
  endtask

  task automatic t_clean();
    send(mk(8'hA5));
    expect_out("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2", "byte_vld one cycle", byte_vld, 1'b0);
    send(mk(8'h3C));
    expect_out("R1", 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stop_fault();
    send(mk(8'h5A) & 16'hFFFE);
    expect_out("R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R3", "link_fault one cycle", link_fault, 1'b0);
    send(mk(8'h5A) | 16'h0002);
    expect_out("R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    send(mk(8'h81));
    expect_out("R3", 1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fix_two_errors();
    send(mk(8'hA5) ^ 16'h0200);
    expect_out("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R4", "rescan one cycle", rescan_req, 1'b0);
    send(mk(8'hA5) ^ 16'h4000);
    expect_out("R5", 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fix_mid();
    send(mk(8'h3C) ^ 16'h0800);
    expect_out("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'h3C));
    expect_out("R5", 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overlap();
    send(mk(8'h69) ^ 16'h0100);
    expect_out("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'h69) ^ 16'h0200);
    expect_out("R7", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    send(mk(8'h12));
    expect_out("R7", 1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_parity_bit_flip();
    send(mk(8'h96) ^ 16'h0020);
    expect_out("R6", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'h96) ^ 16'h8000);
    expect_out("R6", 1'b1, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_second_fault();
    send(mk(8'h44) ^ 16'h1000);
    expect_out("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'h44) & 16'hFFFE);
    expect_out("R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    send(mk(8'h44));
    expect_out("R3", 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_inconsistent();
    send(mk(8'h5A) ^ 16'h8120);
    expect_out("R9", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'h5A));
    expect_out("R9", 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
    send(mk(8'h5A) ^ 16'h8120);
    send(mk(8'h5A) ^ 16'h0100);
    expect_out("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_second_nibble_flip();
    send(mk(8'hC3) ^ 16'h2000);
    expect_out("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    send(mk(8'hC3) ^ 16'h0008);
    expect_out("R10", 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0);
    send(mk(8'hF0) ^ 16'h0100);
    send(mk(8'hF0) ^ 16'h0008);
    expect_out("R10", 1'b1, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    word_vld = 1'b0;
    word_in  = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean();
    t_stop_fault();
    t_fix_two_errors();
    t_fix_mid();
    t_overlap();
    t_parity_bit_flip();
    t_second_fault();
    t_inconsistent();
    t_second_nibble_flip();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule